// File: doc/BRIEF.md
# NAND Ready/Busy Timeout Watchdog

This block guards the busy periods of a NAND flash device. It samples the device's ready/busy line through a synchronizer. When the line turns busy, the block loads a programmed 21-bit timeout value into a down-counter. The counter then drops by one on each tick for as long as the line stays busy. If the count runs out during a busy period, a sticky timeout error flag is raised. That flag can drive an interrupt request when the interrupt is enabled.

The block also keeps the last status byte read back from the flash. The status byte and the live counter value are presented together in a single 32-bit read-only word. The controller around the block issues the flash commands, drives a one-cycle capture strobe when a status byte is valid, and supplies the counting tick.

An asynchronous active-low reset clears every register. Its release is synchronized inside the block, so internal state leaves reset two clock edges after the reset input goes high.

Top module: `nand_rb_watchdog`

## Requirements
- R1: While reset is active, and after it is released with no other stimulus, the read-back word is 0x00000000 and both the error flag and the interrupt request are 0.
- R2: The ready/busy input means busy when 0 and ready when 1, and it reaches the logic through a two-flop synchronizer. After the input falls, the counter field (bits 20:0) still shows its old value after the second rising edge and shows the programmed timeout value after the third.
- R3: While the synchronized line is busy and no busy entry is taking place, each cycle with the tick input high lowers the counter by exactly one.
- R4: While the synchronized line is ready, the counter holds its value: ticks have no effect and nothing reloads it until the next ready-to-busy change.
- R5: Once the counter is 0 it stays 0 under further ticks; it does not wrap.
- R6: The error flag is set on the edge where a decrement brings the counter to 0, or where a busy entry loads a timeout value of 0. It then stays set, also after the line returns to ready, until a cycle with the clear strobe high. A set in the same cycle wins over the clear.
- R7: The interrupt request is high exactly when the error flag is 1 and the interrupt enable input is 1.
- R8: A cycle with the capture strobe high stores the 8-bit status input, which appears in bits 31:24 from the next edge on. Bits 23:21 always read 0, and bits 20:0 carry the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy_busy_n_i | input | 1 | Flash ready/busy line, 0 = busy, asynchronous |
| tick_i | input | 1 | One-cycle count enable |
| tmo_cfg_i | input | 21 | Programmed timeout value |
| tmo_irq_en_i | input | 1 | Timeout interrupt enable |
| err_clr_i | input | 1 | Write-1-to-clear strobe for the error flag |
| stat_cap_i | input | 1 | One-cycle status capture strobe |
| stat_byte_i | input | 8 | Status byte from the flash |
| rdback_o | output | 32 | Read-only word: status, zeros, counter |
| tmo_err_o | output | 1 | Sticky timeout error flag |
| irq_o | output | 1 | Timeout interrupt request |

## Verification
A change on the ready/busy input reaches the counter after three rising edges: two synchronizer flops and the counter register. The bench drives that input on a falling edge. It checks the counter half a cycle after the second rising edge, where the old value must still show, and again after the third, where the loaded value must show. Ticks, clear strobes and capture strobes are each driven high for exactly one rising edge. Their effect on the counter, the error flag or the status field is checked at the next falling edge, and the interrupt output is checked in that same half cycle because it follows the flag with no register in between. Before it ticks, the bench waits three edges after each change of the line, so that no tick falls inside the synchronizer delay.

// File: rtl/nand_rb_wd_pkg.sv
package nand_rb_wd_pkg;
  localparam int unsigned DEF_CNT_W  = 21;
  localparam int unsigned DEF_STAT_W = 8;
  localparam int unsigned WORD_W     = 32;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/nand_rb_wd_sync.sv
module nand_rb_wd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_busy_n_i,
  output logic busy_o,
  output logic entry_o
);
  logic [STAGES-1:0] sh_q;
  logic              busy_d_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[g] <= 1'b1;
        else        sh_q[g] <= rdy_busy_n_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[g] <= 1'b1;
        else        sh_q[g] <= sh_q[g-1];
      end
    end
  end

  assign busy_o = ~sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_d_q <= 1'b0;
    else        busy_d_q <= busy_o;
  end

  assign entry_o = busy_o & ~busy_d_q;
endmodule

// File: rtl/nand_rb_wd_counter.sv
module nand_rb_wd_counter
  import nand_rb_wd_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             entry_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cfg_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cnt_act_e         act;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             err_q, err_nxt, err_set;

  always_comb begin
    if (entry_i)                               act = CNT_LOAD;
    else if (busy_i && tick_i && cnt_q != '0)  act = CNT_DEC;
    else                                       act = CNT_HOLD;
  end

  always_comb begin
    cnt_nxt = cnt_q;
    err_set = 1'b0;
    unique case (act)
      CNT_LOAD: begin
        cnt_nxt = cfg_i;
        err_set = (cfg_i == '0);
      end
      CNT_DEC: begin
        cnt_nxt = cnt_q - ONE;
        err_set = (cnt_q == ONE);
      end
      default: cnt_nxt = cnt_q;
    endcase
  end

  always_comb begin
    if (err_set)    err_nxt = 1'b1;
    else if (clr_i) err_nxt = 1'b0;
    else            err_nxt = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      err_q <= err_nxt;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;
endmodule

// File: rtl/nand_rb_wd_status.sv
module nand_rb_wd_status #(
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [STAT_W-1:0] byte_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q, stat_nxt;

  always_comb stat_nxt = cap_i ? byte_i : stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/nand_rb_watchdog.sv
module nand_rb_watchdog
  import nand_rb_wd_pkg::*;
#(
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned STAT_W      = DEF_STAT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy_busy_n_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  tmo_cfg_i,
  input  logic              tmo_irq_en_i,
  input  logic              err_clr_i,
  input  logic              stat_cap_i,
  input  logic [STAT_W-1:0] stat_byte_i,
  output logic [WORD_W-1:0] rdback_o,
  output logic              tmo_err_o,
  output logic              irq_o
);
  localparam int unsigned RSV_W = WORD_W - CNT_W - STAT_W;

  logic [1:0]        rst_sh_q;
  logic              rst_sync_n;
  logic              busy_sync, busy_entry;
  logic [CNT_W-1:0]  cnt;
  logic              err;
  logic [STAT_W-1:0] stat;

  // reset: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sh_q[1];

  nand_rb_wd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .rdy_busy_n_i (rdy_busy_n_i),
    .busy_o       (busy_sync),
    .entry_o      (busy_entry)
  );

  nand_rb_wd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .busy_i  (busy_sync),
    .entry_i (busy_entry),
    .tick_i  (tick_i),
    .cfg_i   (tmo_cfg_i),
    .clr_i   (err_clr_i),
    .cnt_o   (cnt),
    .err_o   (err)
  );

  nand_rb_wd_status #(.STAT_W(STAT_W)) u_stat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cap_i  (stat_cap_i),
    .byte_i (stat_byte_i),
    .stat_o (stat)
  );

  assign rdback_o  = {stat, {RSV_W{1'b0}}, cnt};
  assign tmo_err_o = err;
  assign irq_o     = err & tmo_irq_en_i;
endmodule

// File: rtl/nand_rb_wd_chk.sv
module nand_rb_wd_chk #(
  parameter int unsigned CNT_W  = 21,
  parameter int unsigned STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              entry,
  input logic              tick,
  input logic [CNT_W-1:0]  cfg,
  input logic              clr,
  input logic [31:0]       word,
  input logic              err,
  input logic              irq,
  input logic              irq_en,
  input logic              cap,
  input logic [STAT_W-1:0] sbyte
);
  logic [CNT_W-1:0] cnt;
  assign cnt = word[CNT_W-1:0];

  AST_LOAD_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> cnt == $past(cfg)); // R2
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !entry && tick && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R3
  AST_HOLD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cnt)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !entry) |=> cnt == '0); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err); // R6
  AST_ERR_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !entry && tick && cnt == CNT_W'(1)) |=> err); // R6
  AST_IRQ_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (err && irq_en)); // R7
  AST_STAT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> word[31:32-STAT_W] == $past(sbyte)); // R8
endmodule

bind nand_rb_watchdog nand_rb_wd_chk #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .busy   (busy_sync),
  .entry  (busy_entry),
  .tick   (tick_i),
  .cfg    (tmo_cfg_i),
  .clr    (err_clr_i),
  .word   (rdback_o),
  .err    (tmo_err_o),
  .irq    (irq_o),
  .irq_en (tmo_irq_en_i),
  .cap    (stat_cap_i),
  .sbyte  (stat_byte_i)
);

// File: tb/nand_rb_watchdog_bench.sv
`timescale 1ns/1ps
module nand_rb_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rb_n, tick, irq_en, clr, cap;
  logic [20:0] cfg;
  logic [7:0]  sbyte;
  logic [31:0] word;
  logic        err, irq;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  always #2.5 clk = ~clk;

  nand_rb_watchdog u_nand_rb_watchdog (
    .clk(clk), .rst_n(rst_n), .rdy_busy_n_i(rb_n), .tick_i(tick),
    .tmo_cfg_i(cfg), .tmo_irq_en_i(irq_en), .err_clr_i(clr),
    .stat_cap_i(cap), .stat_byte_i(sbyte), .rdback_o(word),
    .tmo_err_o(err), .irq_o(irq)
  );

  // {cfg, ticks while busy, expected count, expected error}
  localparam logic [50:0] VEC [0:6] = '{
    {21'd10,       8'd3,  21'd7,        1'b0},
    {21'd5,        8'd5,  21'd0,        1'b1},
    {21'd5,        8'd9,  21'd0,        1'b1},
    {21'd1,        8'd1,  21'd0,        1'b1},
    {21'd0,        8'd0,  21'd0,        1'b1},
    {21'h1FFFFF,   8'd2,  21'h1FFFFD,   1'b0},
    {21'd40,       8'd39, 21'd1,        1'b0}
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic go_busy();  rb_n = 1'b0; cyc(3); endtask
  task automatic go_ready(); rb_n = 1'b1; cyc(3); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [20:0] prev;
    rst_n = 1'b0; rb_n = 1'b1; tick = 1'b0; irq_en = 1'b0; clr = 1'b0;
    cap = 1'b0; cfg = '0; sbyte = '0;
    cyc(3);
    chk("R1 word in reset", word, 32'h0);
    chk("R1 err in reset", {31'b0, err}, 32'h0);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 word after reset", word, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // vector table: R3 R5 R6
    for (int v = 0; v < 7; v++) begin
      go_ready();
      pulse_clr();
      cfg = VEC[v][50:30];
      go_busy();
      pulse_tick(int'(VEC[v][29:22]));
      chk($sformatf("R3 vec %0d count", v), {11'b0, word[20:0]}, {11'b0, VEC[v][21:1]});
      chk($sformatf("R6 vec %0d err", v), {31'b0, err}, {31'b0, VEC[v][0]});
    end

    // R2 synchronizer latency
    go_ready(); pulse_clr();
    prev = word[20:0];
    cfg = 21'd100;
    rb_n = 1'b0;
    cyc(2);
    chk("R2 old count after 2 edges", {11'b0, word[20:0]}, {11'b0, prev});
    cyc(1);
    chk("R2 loaded after 3 edges", {11'b0, word[20:0]}, 32'd100);

    // R4 hold while ready, no reload
    pulse_tick(4);
    chk("R3 count after 4 ticks", {11'b0, word[20:0]}, 32'd96);
    go_ready();
    cfg = 21'd7;
    pulse_tick(6);
    cyc(2);
    chk("R4 count held while ready", {11'b0, word[20:0]}, 32'd96);

    // R5 no wrap, R6 sticky across ready, R7 gating
    cfg = 21'd2;
    go_busy();
    pulse_tick(5);
    chk("R5 count stays zero", {11'b0, word[20:0]}, 32'd0);
    chk("R7 irq masked", {31'b0, irq}, 32'd0);
    irq_en = 1'b1; #0.1;
    chk("R7 irq enabled", {31'b0, irq}, 32'd1);
    go_ready();
    chk("R6 err sticky after ready", {31'b0, err}, 32'd1);
    pulse_clr();
    chk("R6 err cleared", {31'b0, err}, 32'd0);
    chk("R7 irq follows clear", {31'b0, irq}, 32'd0);

    // R6 set wins over same-cycle clear
    cfg = 21'd1;
    go_busy();
    tick = 1'b1; clr = 1'b1; @(negedge clk); tick = 1'b0; clr = 1'b0;
    chk("R6 set beats clear", {31'b0, err}, 32'd1);

    // R8 status field and reserved bits
    sbyte = 8'hA5; cap = 1'b1; @(negedge clk); cap = 1'b0;
    sbyte = 8'h3C; cyc(1);
    chk("R8 status field", {24'b0, word[31:24]}, 32'hA5);
    chk("R8 reserved bits", {29'b0, word[23:21]}, 32'd0);
    go_ready(); pulse_clr();
    cfg = 21'h1FFFFF; go_busy();
    chk("R8 full word", word, 32'hA51FFFFF);

    // R1 reset mid-run
    #1 rst_n = 1'b0; #1;
    chk("R1 word on async reset", word, 32'h0);
    chk("R1 err on async reset", {31'b0, err}, 32'h0);
    cyc(2); rst_n = 1'b1; cyc(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule